// File: doc/BRIEF.md
# Immediate-Operand Accumulator ALU

This block runs one class of two-word instructions whose second word is a 16-bit constant. Words arrive one per accepted cycle on a valid/ready interface. The first word carries a destination select and a 3-bit operation code. The second word is the constant. The block keeps two 40-bit accumulators and a 5-bit status register. It shows both accumulators and the status on its outputs, so a surrounding pipeline or a bench can observe every result.

Each accumulator has three parts: an 8-bit guard top, a 16-bit middle word and a 16-bit bottom word. The constant is aligned with the middle word, not with the bottom bits.

- Add and compare sign-extend the constant and place it on the middle word, with the bottom word zero. The result is computed over all 40 bits.
- Compare keeps only the flags and writes no accumulator.
- XOR, AND and OR change only the middle word.
- The two mask tests leave both accumulators alone and set only the logic-zero flag.

A first word that does not decode raises a one-cycle illegal pulse, and the next word is again taken as a first word.

Top module: `imm_acc_alu`

## Requirements
- R1: A synchronous reset clears both accumulators, all five status bits and `illegal`. `in_ready` is high from the second cycle after reset is released.
- R2: An instruction is a first word of the form 0000 001d ooo0 0000 followed by a second word holding the constant. Bit 8 (d) picks the destination: 0 selects `acc0` and 1 selects `acc1`.
- R3: Operation 000 (add) adds sext(constant)·2^16 to the accumulator, modulo 2^40. The status bits are: bit0 carry out of bit 39, bit1 signed overflow, bit2 result is zero, bit3 result bit 39. Bit4 is unchanged.
- R4: Operation 100 (compare) sets the status bits from accumulator − sext(constant)·2^16:
  - bit0 = 1 when there is no unsigned borrow;
  - bit1 = signed overflow;
  - bit2 = result is zero;
  - bit3 = result bit 39.

  Bit4 is unchanged and the accumulator is not written.
- R5: Operations 001 (XOR), 010 (AND) and 011 (OR) combine bits 31:16 of the accumulator with the constant. Bits 39:32 and 15:0 are unchanged. bit2 = new middle word is zero, bit3 = middle word bit 15, bit0 and bit1 are cleared, and bit4 is unchanged.
- R6: Operation 101 sets bit4 when (middle AND constant) is zero and clears it otherwise. No accumulator and no other status bit changes.
- R7: Operation 110 sets bit4 when (middle AND constant) equals the constant and clears it otherwise. No accumulator and no other status bit changes.
- R8: A first word outside the pattern, or one with operation 111, makes `illegal` high for exactly the cycle after it is accepted. It changes no state, and the following word is decoded as a first word.
- R9: Results and flags appear in the cycle after the constant word is accepted. Cycles with `in_valid` low are ignored, including a gap between the two words.
- R10: An instruction changes at most the accumulator its d bit names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word (first word or constant) |
| in_ready | output | 1 | Block accepts a word this cycle |
| illegal | output | 1 | One-cycle pulse for an undecodable first word |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| status | output | 5 | {logic-zero, sign, zero, overflow, carry} |

## Verification
The bench builds the block with its default part widths: an 8-bit guard, a 16-bit middle and a 16-bit bottom. With these widths the largest positive add step is just under 2^31, so 257 repeated adds carry the accumulator across 2^39 and bring signed overflow within reach. A constant with bit 15 set, or the value 0xFFFF, exercises sign extension into the guard bits and a carry out of bit 39. Mask tests with zero and full constants reach both outcomes of each logic-zero rule.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_XOR  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_CMP  = 3'b100,
        OP_TSTZ = 3'b101,
        OP_TSTM = 3'b110,
        OP_RSV  = 3'b111
    } alu_op_e;

    // Packed MSB first: lz is bit 4, cry is bit 0.
    typedef struct packed {
        logic lz;
        logic sgn;
        logic zro;
        logic ovf;
        logic cry;
    } flags_t;

    localparam int FLAGS_W = $bits(flags_t);

endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
    import imm_alu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word,
    output logic              legal,
    output logic              dst,
    output alu_op_e           op
);
    localparam int SEL_BIT = 8;
    localparam int OP_LSB  = 5;
    localparam int PFX_W   = WORD_W - SEL_BIT - 1;

    logic [PFX_W-1:0] prefix;
    logic [OP_LSB-1:0] tail;

    always_comb begin
        prefix = word[WORD_W-1:SEL_BIT+1];
        tail   = word[OP_LSB-1:0];
        dst    = word[SEL_BIT];
        op     = alu_op_e'(word[OP_LSB+2:OP_LSB]);
        legal  = (prefix == PFX_W'(1)) && (tail == '0) && (op != OP_RSV);
    end

endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
    import imm_alu_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int MID_W = 16,
    parameter int LO_W  = 16
) (
    input  alu_op_e                        op,
    input  logic [HI_W+MID_W+LO_W-1:0]     acc_in,
    input  logic [MID_W-1:0]               imm,
    input  flags_t                         flg_in,
    output logic [HI_W+MID_W+LO_W-1:0]     acc_out,
    output logic                           wr,
    output flags_t                         flg_out
);
    localparam int ACC_W = HI_W + MID_W + LO_W;
    localparam int MSB   = ACC_W - 1;
    localparam logic [ACC_W:0] ONE = {{ACC_W{1'b0}}, 1'b1};

    logic [ACC_W-1:0] opnd;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   dif;
    logic [MID_W-1:0] mid;
    logic [MID_W-1:0] mid_res;
    logic [MID_W-1:0] masked;

    always_comb begin
        opnd    = {{HI_W{imm[MID_W-1]}}, imm, {LO_W{1'b0}}};
        sum     = {1'b0, acc_in} + {1'b0, opnd};
        dif     = {1'b0, acc_in} + {1'b0, ~opnd} + ONE;
        mid     = acc_in[LO_W +: MID_W];
        masked  = mid & imm;
        mid_res = mid;
        acc_out = acc_in;
        wr      = 1'b0;
        flg_out = flg_in;
        unique case (op)
            OP_ADD: begin
                acc_out     = sum[ACC_W-1:0];
                wr          = 1'b1;
                flg_out.cry = sum[ACC_W];
                flg_out.ovf = (acc_in[MSB] == opnd[MSB]) && (sum[MSB] != acc_in[MSB]);
                flg_out.zro = (sum[ACC_W-1:0] == '0);
                flg_out.sgn = sum[MSB];
            end
            OP_CMP: begin
                flg_out.cry = dif[ACC_W];
                flg_out.ovf = (acc_in[MSB] != opnd[MSB]) && (dif[MSB] != acc_in[MSB]);
                flg_out.zro = (dif[ACC_W-1:0] == '0);
                flg_out.sgn = dif[MSB];
            end
            OP_XOR, OP_AND, OP_OR: begin
                if (op == OP_XOR)      mid_res = mid ^ imm;
                else if (op == OP_AND) mid_res = masked;
                else                   mid_res = mid | imm;
                acc_out[LO_W +: MID_W] = mid_res;
                wr          = 1'b1;
                flg_out.cry = 1'b0;
                flg_out.ovf = 1'b0;
                flg_out.zro = (mid_res == '0);
                flg_out.sgn = mid_res[MID_W-1];
            end
            OP_TSTZ: flg_out.lz = (masked == '0);
            OP_TSTM: flg_out.lz = (masked == imm);
            default: ;
        endcase
    end

endmodule

// File: rtl/imm_acc_alu.sv
module imm_acc_alu
    import imm_alu_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int MID_W = 16,
    parameter int LO_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [MID_W-1:0]               in_word,
    output logic                           in_ready,
    output logic                           illegal,
    output logic [HI_W+MID_W+LO_W-1:0]     acc0,
    output logic [HI_W+MID_W+LO_W-1:0]     acc1,
    output logic [FLAGS_W-1:0]             status
);
    localparam int ACC_W   = HI_W + MID_W + LO_W;
    localparam int NUM_ACC = 2;

    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
        flags_t                        flg;
        logic                          imm_phase;
        logic                          dst;
        alu_op_e                       op;
        logic                          illegal;
        logic                          ready;
    } state_t;

    state_t st_d, st_q;

    logic             dec_legal;
    logic             dec_dst;
    alu_op_e          dec_op;
    logic [ACC_W-1:0] ex_acc;
    logic             ex_wr;
    flags_t           ex_flg;
    logic             accept;

    imm_alu_decode #(.WORD_W(MID_W)) u_dec (
        .word  (in_word),
        .legal (dec_legal),
        .dst   (dec_dst),
        .op    (dec_op)
    );

    imm_alu_exec #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_exec (
        .op      (st_q.op),
        .acc_in  (st_q.acc[st_q.dst]),
        .imm     (in_word),
        .flg_in  (st_q.flg),
        .acc_out (ex_acc),
        .wr      (ex_wr),
        .flg_out (ex_flg)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        st_d.ready   = 1'b1;
        accept       = in_valid && st_q.ready;
        if (accept) begin
            if (!st_q.imm_phase) begin
                if (dec_legal) begin
                    st_d.imm_phase = 1'b1;
                    st_d.dst       = dec_dst;
                    st_d.op        = dec_op;
                end else begin
                    st_d.illegal = 1'b1;
                end
            end else begin
                st_d.imm_phase = 1'b0;
                st_d.flg       = ex_flg;
                if (ex_wr) begin
                    st_d.acc[st_q.dst] = ex_acc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = st_q.ready;
    assign illegal  = st_q.illegal;
    assign acc0     = st_q.acc[0];
    assign acc1     = st_q.acc[1];
    assign status   = st_q.flg;

endmodule

// File: rtl/imm_acc_alu_chk.sv
module imm_acc_alu_chk #(
    parameter int ACC_W = 40,
    parameter int LO_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             illegal,
    input logic [ACC_W-1:0] acc0,
    input logic [ACC_W-1:0] acc1,
    input logic [4:0]       status
);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc0 == '0) && (acc1 == '0) && (status == '0) && !illegal);

    assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> in_ready);

    assert_low_word_kept_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(acc0[LO_W-1:0]) && $stable(acc1[LO_W-1:0]));

    assert_illegal_no_effect_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(acc0) && $stable(acc1) && $stable(status));

    assert_illegal_needs_word_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $past(in_valid));

    assert_single_dest_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !(!$stable(acc0) && !$stable(acc1)));

endmodule

bind imm_acc_alu imm_acc_alu_chk #(.ACC_W(ACC_W), .LO_W(LO_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .illegal  (illegal),
    .acc0     (acc0),
    .acc1     (acc1),
    .status   (status)
);

// File: tb/test_imm_acc_alu.sv
module test_imm_acc_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0;
    logic        in_ready;
    logic        illegal;
    logic [39:0] acc0;
    logic [39:0] acc1;
    logic [4:0]  status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    imm_acc_alu i_imm_acc_alu (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_word  (in_word),
        .in_ready (in_ready),
        .illegal  (illegal),
        .acc0     (acc0),
        .acc1     (acc1),
        .status   (status)
    );

    typedef struct packed {
        logic [15:0] w0;
        logic [15:0] imm;
        logic [39:0] a0;
        logic [39:0] a1;
        logic [4:0]  st;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    // status = {lz, sign, zero, overflow, carry}
    localparam vec_t VECS [NV] = '{
        {16'h0200, 16'h1234, 40'h0012340000, 40'h0000000000, 5'h00, 4'd3},  // R3 add
        {16'h0300, 16'h8000, 40'h0012340000, 40'hFF80000000, 5'h08, 4'd2},  // R2 acc1 select
        {16'h0300, 16'h8000, 40'h0012340000, 40'hFF00000000, 5'h09, 4'd3},  // R3 carry out
        {16'h0280, 16'h1234, 40'h0012340000, 40'hFF00000000, 5'h05, 4'd4},  // R4 equal
        {16'h0220, 16'hFFFF, 40'h00EDCB0000, 40'hFF00000000, 5'h08, 4'd5},  // R5 xor
        {16'h0280, 16'h2000, 40'h00EDCB0000, 40'hFF00000000, 5'h01, 4'd4},  // R4 no borrow
        {16'h0240, 16'h00F0, 40'h0000C00000, 40'hFF00000000, 5'h00, 4'd5},  // R5 and
        {16'h0360, 16'h0000, 40'h0000C00000, 40'hFF00000000, 5'h04, 4'd5},  // R5 or, guard kept
        {16'h0380, 16'h0001, 40'h0000C00000, 40'hFF00000000, 5'h09, 4'd4},  // R4 negative
        {16'h02A0, 16'h0F00, 40'h0000C00000, 40'hFF00000000, 5'h19, 4'd6},  // R6 set
        {16'h02C0, 16'h00C1, 40'h0000C00000, 40'hFF00000000, 5'h09, 4'd7},  // R7 clear
        {16'h02C0, 16'h0040, 40'h0000C00000, 40'hFF00000000, 5'h19, 4'd7},  // R7 set
        {16'h02A0, 16'h0080, 40'h0000C00000, 40'hFF00000000, 5'h09, 4'd6},  // R6 clear
        {16'h03C0, 16'h0000, 40'h0000C00000, 40'hFF00000000, 5'h19, 4'd7},  // R7 zero mask
        {16'h0200, 16'hFFFF, 40'h0000BF0000, 40'hFF00000000, 5'h11, 4'd3},  // R3 lz kept
        {16'h0320, 16'h8000, 40'h0000BF0000, 40'hFF80000000, 5'h18, 4'd10}, // R10 only acc1
        {16'h0200, 16'hFF41, 40'h0000000000, 40'hFF80000000, 5'h15, 4'd3}   // R3 zero result
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [39:0] a0,
                             input logic [39:0] a1, input logic [4:0] st);
        chk(req, {24'h0, acc0}, {24'h0, a0});
        chk(req, {24'h0, acc1}, {24'h0, a1});
        chk(req, {59'h0, status}, {59'h0, st});
    endtask

    task automatic issue(input logic [15:0] w0, input logic [15:0] imm);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w0;
        @(negedge clk);
        in_word  = imm;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk_state("R1", 40'h0, 40'h0, 5'h00);
        chk("R1", {63'h0, illegal}, 64'h0);
        chk("R1", {63'h0, in_ready}, 64'h1);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].w0, VECS[i].imm);
            chk_state($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].a0, VECS[i].a1, VECS[i].st);
        end

        // R9 gap between first word and constant
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 16'h0260;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 16'hFFFF;
        chk_state("R9 gap", 40'h0000000000, 40'hFF80000000, 5'h15);
        repeat (2) @(negedge clk);
        in_valid = 1'b1;
        in_word  = 16'h0003;
        @(negedge clk);
        in_valid = 1'b0;
        chk_state("R9 after gap", 40'h0000030000, 40'hFF80000000, 5'h10);

        // R8 reserved operation
        in_valid = 1'b1;
        in_word  = 16'h02E0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 pulse", {63'h0, illegal}, 64'h1);
        chk_state("R8 no change", 40'h0000030000, 40'hFF80000000, 5'h10);
        @(negedge clk);
        chk("R8 one cycle", {63'h0, illegal}, 64'h0);

        // R8 nonzero low bits
        in_valid = 1'b1;
        in_word  = 16'h0201;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 low bits", {63'h0, illegal}, 64'h1);

        // R8 bad prefix directly followed by a legal instruction
        in_valid = 1'b1;
        in_word  = 16'h0A00;
        @(negedge clk);
        chk("R8 prefix", {63'h0, illegal}, 64'h1);
        in_word  = 16'h0300;
        @(negedge clk);
        chk("R8 next decoded", {63'h0, illegal}, 64'h0);
        in_word  = 16'h0080;
        @(negedge clk);
        in_valid = 1'b0;
        chk_state("R8 resume", 40'h0000030000, 40'hFF80800000, 5'h18);

        // R1 reset in mid run
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_state("R1 mid reset", 40'h0, 40'h0, 5'h00);
        chk("R1 mid reset", {63'h0, illegal}, 64'h0);
        @(negedge clk);

        // R3 signed overflow after 257 large adds
        for (int k = 0; k < 256; k++) begin
            issue(16'h0200, 16'h7FFF);
        end
        chk_state("R3 near limit", 40'h7FFF000000, 40'h0, 5'h00);
        issue(16'h0200, 16'h7FFF);
        chk_state("R3 overflow", 40'h807EFF0000, 40'h0, 5'h0A);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule